// File: doc/BRIEF.md
# NMI Status and Speaker Control Register

This block is the legacy system-control byte that sits between the error sources, a timer with three channels and the speaker. Software writes the low nibble to set two active-low error enables, the speaker mask and the gate level of timer channel 2. When software reads the byte it sees the low nibble it wrote, two latched error flags, the live output of timer channel 2 and a bit that flips on each falling edge of timer channel 1. The block raises an NMI request while an enabled error flag is set.

A read returns the register state as it stands, with no wait cycles. A write takes effect at the next clock edge when `wr_en` is high. The error flags do not use write-one-to-clear on the flag bits. A flag is cleared by writing 1 to its own enable bit, and that same write masks the source. Both error inputs and the timer channel 1 output are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops (2 by default). Each error flag is a two-state machine with the states ERR_CLEAR and ERR_HELD. The transition *set* (ERR_CLEAR to ERR_HELD) fires when the synchronized error is active and the enable bit is 0, and no clear is requested in the same cycle. The transition *clear* (ERR_HELD to ERR_CLEAR) fires on a write that carries 1 in the enable bit. The channel 1 edge detector is a two-state machine with the states LVL_LOW and LVL_HIGH. The transition *rise* (LVL_LOW to LVL_HIGH) has no side effect. The transition *fall* (LVL_HIGH to LVL_LOW) inverts the toggle bit.

Top module: `nmi_spkr_ctrl`

## Requirements
- R1: After reset, `rd_data` reads {0,0,`tmr2_out`,0,1,1,0,0} from bit 7 down to bit 0. At the same time `tmr2_gate`, `spkr_out` and `nmi_req` are 0.
- R2: A write stores `wr_data[3:0]` into `rd_data[3:0]` at the next clock edge. Bits 7..4 of a write have no effect on any bit that is read back.
- R3: While bit 2 is 0, a low `bus_err_n` sets bit 7 at the third rising edge after the input falls. Bit 7 stays set after the input returns high.
- R4: While bit 2 is 1, a low `bus_err_n` leaves bit 7 at 0.
- R5: A write with bit 2 = 1 clears bit 7 at the next edge. A write with bit 2 = 0 leaves bit 7 unchanged.
- R6: While bit 3 is 0, a low `io_chk_n` sets bit 6 at the third rising edge after the input falls, and bit 6 stays set. While bit 3 is 1, bit 6 does not set.
- R7: A write with bit 3 = 1 clears bit 6 at the next edge. A write with bit 3 = 0 leaves bit 6 unchanged.
- R8: `nmi_req` = (bit7 AND NOT bit2) OR (bit6 AND NOT bit3). It has no added latency.
- R9: Bit 5 of `rd_data` equals `tmr2_out` in the same cycle, and writes do not affect it.
- R10: `spkr_out` = `tmr2_out` AND bit 1. It is combinational.
- R11: `tmr2_gate` equals bit 0.
- R12: Bit 4 inverts at the third rising edge after each falling edge of `tmr1_out`. A rising edge of `tmr1_out` leaves bit 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| bus_err_n | input | 1 | Bus parity/system error, active low, asynchronous |
| io_chk_n | input | 1 | I/O channel check, active low, asynchronous |
| tmr1_out | input | 1 | Timer channel 1 output, asynchronous |
| tmr2_out | input | 1 | Timer channel 2 output |
| tmr2_gate | output | 1 | Gate input of timer channel 2 |
| spkr_out | output | 1 | Masked speaker drive |
| nmi_req | output | 1 | NMI request |

## Verification
Results arrive at three different latencies. Register bits, the gate and the error clears take effect one rising edge after the write. The error flags and the toggle bit change at the third rising edge after the input moves. Bit 5, `spkr_out` and `nmi_req` follow their inputs within the same cycle. The bench applies each stimulus at a falling edge and samples at falling edges. For the synchronized paths it checks that the result has not yet changed two edges after the stimulus and has changed after the third edge, so both an early result and a late one are caught.

// File: rtl/nmi_spkr_pkg.sv
package nmi_spkr_pkg;

    // Control nibble positions
    localparam int unsigned GATE_BIT  = 0;
    localparam int unsigned SPKEN_BIT = 1;
    localparam int unsigned BUSEN_BIT = 2;
    localparam int unsigned IOEN_BIT  = 3;
    localparam int unsigned CTRL_W    = 4;

    localparam logic [CTRL_W-1:0] CTRL_RST = 4'b1100;

    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_err_latch.sv
module nmi_err_latch
    import nmi_spkr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_act,
    input  logic mask,
    input  logic clr,
    output logic held
);
    err_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR: if (err_act && !mask && !clr) state_d = ERR_HELD;
            ERR_HELD:  if (clr)                      state_d = ERR_CLEAR;
            default:   state_d = ERR_CLEAR;
        endcase
    end

    assign held = (state_q == ERR_HELD);

    // R5, R7: a clearing write empties the flag at the next edge
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !held);

    // R4, R6: a masked source cannot set the flag
    a_r4_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !held) |=> !held);

    // R3, R6: once held, the flag leaves only through a clear
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> held);

endmodule

// File: rtl/nmi_edge_toggle.sv
module nmi_edge_toggle
    import nmi_spkr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic toggle
);
    lvl_state_t state_q, state_d;
    logic       tog_q;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW:  if (lvl)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl) begin
                state_d = LVL_LOW;
                fall    = 1'b1;
            end
            default:  state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tog_q <= 1'b0;
        else if (fall) tog_q <= ~tog_q;
    end

    assign toggle = tog_q;

    // R12: the toggle moves only on a high-to-low step of the tracked level
    a_r12_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_q) |-> ($past(state_q) == LVL_HIGH && state_q == LVL_LOW));

endmodule

// File: rtl/nmi_spkr_ctrl.sv
module nmi_spkr_ctrl
    import nmi_spkr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       bus_err_n,
    input  logic       io_chk_n,
    input  logic       tmr1_out,
    input  logic       tmr2_out,
    output logic       tmr2_gate,
    output logic       spkr_out,
    output logic       nmi_req
);
    logic [CTRL_W-1:0] ctrl_q;
    logic bus_sync_n, io_sync_n, tmr1_sync;
    logic bus_held, io_held, toggle;
    logic bus_clr, io_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= CTRL_RST;
        else if (wr_en) ctrl_q <= wr_data[CTRL_W-1:0];
    end

    assign bus_clr = wr_en & wr_data[BUSEN_BIT];
    assign io_clr  = wr_en & wr_data[IOEN_BIT];

    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .async_i(bus_err_n), .sync_o(bus_sync_n));
    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_io_sync (
        .clk(clk), .rst_n(rst_n), .async_i(io_chk_n), .sync_o(io_sync_n));
    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_t1_sync (
        .clk(clk), .rst_n(rst_n), .async_i(tmr1_out), .sync_o(tmr1_sync));

    nmi_err_latch u_bus_flag (
        .clk(clk), .rst_n(rst_n), .err_act(!bus_sync_n),
        .mask(ctrl_q[BUSEN_BIT]), .clr(bus_clr), .held(bus_held));
    nmi_err_latch u_io_flag (
        .clk(clk), .rst_n(rst_n), .err_act(!io_sync_n),
        .mask(ctrl_q[IOEN_BIT]), .clr(io_clr), .held(io_held));

    nmi_edge_toggle u_t1_edge (
        .clk(clk), .rst_n(rst_n), .lvl(tmr1_sync), .toggle(toggle));

    always_comb begin
        rd_data   = {bus_held, io_held, tmr2_out, toggle, ctrl_q};
        tmr2_gate = ctrl_q[GATE_BIT];
        spkr_out  = tmr2_out & ctrl_q[SPKEN_BIT];
        nmi_req   = (bus_held & ~ctrl_q[BUSEN_BIT]) | (io_held & ~ctrl_q[IOEN_BIT]);
    end

    // R8: a request needs a held flag behind it
    a_r8_nmi_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (bus_held || io_held));

    // R10: the speaker never drives without the timer output
    a_r10_spkr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_out |-> tmr2_out);

    // R2, R11: the control nibble and gate hold without a write
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[3:0]));

    a_r11_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tmr2_gate));

endmodule

// File: tb/nmi_spkr_ctrl_tb_top.sv
module nmi_spkr_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       bus_err_n = 1'b1;
    logic       io_chk_n = 1'b1;
    logic       tmr1_out = 1'b0;
    logic       tmr2_out = 1'b0;
    logic       tmr2_gate, spkr_out, nmi_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nmi_spkr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_err_n(bus_err_n), .io_chk_n(io_chk_n),
        .tmr1_out(tmr1_out), .tmr2_out(tmr2_out), .tmr2_gate(tmr2_gate),
        .spkr_out(spkr_out), .nmi_req(nmi_req));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    // Vector fields: write data, tmr2_out, expected nibble, expected speaker, expected gate
    localparam int NVEC = 8;
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h03, 1'b1, 4'h3, 1'b1, 1'b1},
        {8'h03, 1'b0, 4'h3, 1'b0, 1'b1},
        {8'hF2, 1'b1, 4'h2, 1'b1, 1'b0},
        {8'h01, 1'b1, 4'h1, 1'b0, 1'b1},
        {8'hA0, 1'b1, 4'h0, 1'b0, 1'b0},
        {8'h5E, 1'b1, 4'hE, 1'b1, 1'b0},
        {8'hFF, 1'b0, 4'hF, 1'b0, 1'b1},
        {8'h7C, 1'b1, 4'hC, 1'b0, 1'b0}
    };

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h0C);
        check("R1 outputs", {5'd0, tmr2_gate, spkr_out, nmi_req}, 8'h00);

        // R2, R9, R10, R11 vector walk
        for (int i = 0; i < NVEC; i++) begin
            tmr2_out = VEC[i][6];
            do_write(VEC[i][14:7]);
            check("R2 nibble / upper ignored", rd_data,
                  {2'b00, VEC[i][6], 1'b0, VEC[i][5:2]});
            check("R10 speaker", {7'd0, spkr_out}, {7'd0, VEC[i][1]});
            check("R11 gate", {7'd0, tmr2_gate}, {7'd0, VEC[i][0]});
        end

        // R9 live tmr2 with no latency
        tmr2_out = 1'b0;
        #1;
        check("R9 live tmr2", {7'd0, rd_data[5]}, 8'h00);
        tmr2_out = 1'b1;
        #1;
        check("R9 live tmr2", {7'd0, rd_data[5]}, 8'h01);

        // R4 masked bus error (bit2 = 1 from last vector)
        do_write(8'h04);
        @(negedge clk); bus_err_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 masked bus error", {7'd0, rd_data[7]}, 8'h00);
        bus_err_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 bus error set timing, enabled
        do_write(8'h00);
        bus_err_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 not yet set", {7'd0, rd_data[7]}, 8'h00);
        @(negedge clk);
        check("R3 set at third edge", {7'd0, rd_data[7]}, 8'h01);
        check("R8 nmi from bus", {7'd0, nmi_req}, 8'h01);
        bus_err_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 sticky", {7'd0, rd_data[7]}, 8'h01);

        // R5 write with bit2 = 0 keeps, bit2 = 1 clears
        do_write(8'h08);
        check("R5 keep on bit2=0", {7'd0, rd_data[7]}, 8'h01);
        do_write(8'h04);
        check("R5 clear on bit2=1", {7'd0, rd_data[7]}, 8'h00);
        check("R8 nmi dropped", {7'd0, nmi_req}, 8'h00);

        // R6 masked io check
        do_write(8'h08);
        io_chk_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 masked io check", {7'd0, rd_data[6]}, 8'h00);
        io_chk_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 enabled io check timing
        do_write(8'h04);
        io_chk_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 not yet set", {7'd0, rd_data[6]}, 8'h00);
        @(negedge clk);
        check("R6 set at third edge", {7'd0, rd_data[6]}, 8'h01);
        check("R8 nmi from io", {7'd0, nmi_req}, 8'h01);
        io_chk_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7 keep then clear
        do_write(8'h04);
        check("R7 keep on bit3=0", {7'd0, rd_data[6]}, 8'h01);
        do_write(8'h0C);
        check("R7 clear on bit3=1", {7'd0, rd_data[6]}, 8'h00);
        check("R8 nmi idle", {7'd0, nmi_req}, 8'h00);

        // R12 toggle on falling edges only
        tmr1_out = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 rise ignored", {7'd0, rd_data[4]}, 8'h00);
        tmr1_out = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 not yet flipped", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        check("R12 flipped", {7'd0, rd_data[4]}, 8'h01);
        tmr1_out = 1'b1;
        repeat (4) @(negedge clk);
        tmr1_out = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 flipped back", {7'd0, rd_data[4]}, 8'h00);

        // R1 reset again in the middle of activity
        do_write(8'h03);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tmr2_out = 1'b0;
        @(negedge clk);
        check("R1 reset after use", rd_data, 8'h0C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule